// File: doc/BRIEF.md
# Calibration Pulse Generator with Reverse-Power Flag

This block turns a stream of signed, already filtered real-power samples into a fast, active-high calibration pulse train. The pulse rate follows near-instantaneous power. A signed accumulator adds every qualified sample. Each time the running total reaches a positive or negative threshold, one pulse is issued and the threshold is removed from the total. Any residue is kept, so over many pulses the rate is exact.

The threshold is a base value divided by a scale factor. The scale factor is decoded from a calibration-scale select and a two-bit rate select. One decode gives a very fast mode whose pulses have a fixed short width.

Normally a pulse stays high for a long nominal width. When pulses come closer together than twice that width, each pulse lasts half of the period that ends with it. A reverse-power flag shows which way the total crossed for the latest pulse. The flag changes only at the moment a pulse is issued. Samples too small to count are dropped, so an idle load produces no pulses.

Top module: `cal_pulse_gen`

## Requirements
- R1: After reset, `cal_pulse` and `rev_flag` are low.
- R2: With `cal_sel`=1, `rate_sel` values 0, 1, 2 and 3 set the threshold to BASE_THR/128, /64, /32 and /16. With a steady sample p on every cycle (p dividing the threshold), pulses start every threshold/|p| cycles.
- R3: With `cal_sel`=0, `rate_sel` values 0, 1 and 2 set the threshold to BASE_THR/64, /32 and /16, and `rate_sel`=3 sets it to BASE_THR/2048.
- R4: A pulse stays high for min(WIDE_CYC, floor(P/2)) cycles, and never less than one. P is the number of clock cycles from the previous pulse start to this one.
- R5: With `cal_sel`=0 and `rate_sel`=3, every pulse stays high for exactly FAST_CYC cycles, whatever the period.
- R6: `rev_flag` is set to 1 when a pulse comes from a negative crossing and to 0 when it comes from a positive crossing. It changes only in the cycle in which a pulse starts.
- R7: A sample whose magnitude is below CREEP_LVL is not accumulated, so a constant sample of that size produces no pulses and leaves `rev_flag` unchanged.
- R8: When `smp_vld` is 0, `smp_pwr` is ignored and no pulse starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Power sample valid this cycle |
| smp_pwr | input | PW | Signed real-power sample |
| rate_sel | input | 2 | Rate select shared with the low-rate output |
| cal_sel | input | 1 | Calibration-scale select |
| cal_pulse | output | 1 | Active-high calibration pulse |
| rev_flag | output | 1 | High when the latest pulse came from negative power |

## Verification
The assertions assume that the magnitude of a sample never exceeds the current threshold, so each sample causes at most one crossing. They also assume that FAST_CYC is no larger than WIDE_CYC. Every stimulus value divides its threshold exactly, from a power of two down to 4. Selects change only while the previous pulse is ending or has ended. The period is measured only once the residue has settled, after two pulses at each setting.

// File: rtl/cal_pulse_gen.sv
module cal_pulse_gen #(
  parameter int PW        = 16,
  parameter int BASE_THR  = 1 << 20,
  parameter int WIDE_CYC  = 90000,
  parameter int FAST_CYC  = 35,
  parameter int CREEP_LVL = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_vld,
  input  logic signed [PW-1:0] smp_pwr,
  input  logic [1:0]           rate_sel,
  input  logic                 cal_sel,
  output logic                 cal_pulse,
  output logic                 rev_flag
);
  localparam int AW      = PW + $clog2(BASE_THR) + 2;
  localparam int CYC_MAX = 2 * WIDE_CYC;
  localparam int CW      = $clog2(((CYC_MAX > FAST_CYC) ? CYC_MAX : FAST_CYC) + 1);
  localparam logic [AW-1:0] BASE_L = AW'(BASE_THR);

  logic signed [AW-1:0] acc, acc_nx, thr, smp_x;
  logic [PW:0]          mag;
  logic [3:0]           shift;
  logic [CW-1:0]        cyc, half, wload, tmr;
  logic                 fast, take, pos_fire, neg_fire, fire;

  always_comb begin
    unique case ({cal_sel, rate_sel})
      3'b100:  shift = 4'd7;
      3'b101:  shift = 4'd6;
      3'b110:  shift = 4'd5;
      3'b111:  shift = 4'd4;
      3'b000:  shift = 4'd6;
      3'b001:  shift = 4'd5;
      3'b010:  shift = 4'd4;
      default: shift = 4'd11;
    endcase
  end

  assign thr      = signed'(BASE_L >> shift);
  assign fast     = !cal_sel && (rate_sel == 2'b11);
  assign smp_x    = AW'(smp_pwr);
  assign mag      = smp_pwr[PW-1] ? (PW+1)'(-smp_x) : (PW+1)'(smp_x);
  assign take     = smp_vld && (mag >= (PW+1)'(CREEP_LVL));
  assign acc_nx   = acc + smp_x;
  assign pos_fire = take && (acc_nx >= thr);
  assign neg_fire = take && (acc_nx <= -thr);
  assign fire     = pos_fire || neg_fire;

  assign half  = cyc >> 1;
  assign wload = fast                       ? CW'(FAST_CYC) :
                 (half >= CW'(WIDE_CYC))    ? CW'(WIDE_CYC) :
                 (half == '0)               ? CW'(1)        : half;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (pos_fire) begin
      acc <= acc_nx - thr;
    end else if (neg_fire) begin
      acc <= acc_nx + thr;
    end else if (take) begin
      acc <= acc_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc <= CW'(CYC_MAX);
    end else if (fire) begin
      cyc <= CW'(1);
    end else if (cyc < CW'(CYC_MAX)) begin
      cyc <= cyc + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cal_pulse <= 1'b0;
      tmr       <= '0;
      rev_flag  <= 1'b0;
    end else if (fire) begin
      cal_pulse <= 1'b1;
      tmr       <= wload;
      rev_flag  <= neg_fire;
    end else if (cal_pulse) begin
      if (tmr <= CW'(1)) begin
        cal_pulse <= 1'b0;
        tmr       <= '0;
      end else begin
        tmr <= tmr - CW'(1);
      end
    end
  end

  logic [CW-1:0] hi_run;
  always_ff @(posedge clk) begin
    if (!rst_n)         hi_run <= '0;
    else if (fire)      hi_run <= CW'(1);
    else if (cal_pulse && hi_run < CW'(CYC_MAX)) hi_run <= hi_run + CW'(1);
    else if (!cal_pulse) hi_run <= '0;
  end

  a_r6_flag_moves_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rev_flag) |-> cal_pulse);
  a_r8_pulse_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_pulse) |-> $past(smp_vld));
  a_r7_pulse_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_pulse) |-> $past(mag) >= (PW+1)'(CREEP_LVL));
  a_r4_high_run_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cal_pulse |-> hi_run <= CW'(WIDE_CYC));
  a_r1_idle_after_reset: assert property (@(posedge clk)
    $past(!rst_n) |-> !cal_pulse && !rev_flag);
endmodule

// File: tb/test_cal_pulse_gen.sv
module test_cal_pulse_gen;
  localparam int PW = 16, BASE = 65536, WIDE = 40, FAST = 3, CREEP = 2;

  logic clk = 1'b0, rst_n = 1'b0, smp_vld = 1'b0, cal_sel = 1'b0;
  logic signed [PW-1:0] smp_pwr = '0;
  logic [1:0] rate_sel = 2'b00;
  logic cal_pulse, rev_flag;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cal_pulse_gen #(.PW(PW), .BASE_THR(BASE), .WIDE_CYC(WIDE), .FAST_CYC(FAST),
                  .CREEP_LVL(CREEP)) i_cal_pulse_gen (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_pwr(smp_pwr),
    .rate_sel(rate_sel), .cal_sel(cal_sel), .cal_pulse(cal_pulse), .rev_flag(rev_flag));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 pulse low", cal_pulse, 0);
    check("R1 flag low", rev_flag, 0);
  endtask

  task automatic t_rate(input bit cs, input logic [1:0] rs, input int p,
                        input int exp_p, input int exp_w, input string req);
    int rise[4];
    int fall = -1, nr = 0, t = 0;
    bit prev;
    @(negedge clk);
    cal_sel = cs; rate_sel = rs; smp_pwr = PW'(p); smp_vld = 1'b1;
    prev = cal_pulse;
    while (nr < 4 && t < 4000) begin
      @(negedge clk);
      t++;
      if (cal_pulse && !prev) begin rise[nr] = t; nr++; end
      if (!cal_pulse && prev && nr == 3 && fall < 0) fall = t;
      prev = cal_pulse;
    end
    check({req, " pulses seen"}, nr, 4);
    if (nr == 4) begin
      check({req, " period"}, rise[3] - rise[2], exp_p);
      check({req, " width"}, fall - rise[2], exp_w);
    end
  endtask

  task automatic t_reverse();
    int t = 0, early = 0, at_rise = -1;
    bit prev;
    @(negedge clk);
    cal_sel = 1'b1; rate_sel = 2'b00; smp_pwr = -PW'(32);
    prev = cal_pulse;
    while (at_rise < 0 && t < 2000) begin
      @(negedge clk);
      t++;
      if (cal_pulse && !prev) at_rise = rev_flag;
      else if (rev_flag) early++;
      prev = cal_pulse;
    end
    check("R6 flag held until pulse", early, 0);
    check("R6 flag set at negative pulse", at_rise, 1);
    smp_pwr = PW'(32);
    at_rise = -1; early = 0; t = 0;
    while (at_rise < 0 && t < 2000) begin
      @(negedge clk);
      t++;
      if (cal_pulse && !prev) at_rise = rev_flag;
      else if (!rev_flag) early++;
      prev = cal_pulse;
    end
    check("R6 flag held high until pulse", early, 0);
    check("R6 flag cleared at positive pulse", at_rise, 0);
  endtask

  task automatic t_quiet(input bit vld, input int p, input string req);
    int rises = 0, moves = 0;
    bit prev, f0;
    @(negedge clk);
    cal_sel = 1'b0; rate_sel = 2'b11; smp_vld = vld; smp_pwr = PW'(p);
    repeat (60) @(negedge clk);
    prev = cal_pulse; f0 = rev_flag;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (cal_pulse && !prev) rises++;
      if (rev_flag != f0) moves++;
      prev = cal_pulse;
    end
    check({req, " no pulses"}, rises, 0);
    check({req, " flag unchanged"}, moves, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rate(1'b1, 2'b00, 32, 16, 8, "R2 code 00");
    t_rate(1'b1, 2'b01, 32, 32, 16, "R2 code 01");
    t_rate(1'b1, 2'b10, 32, 64, 32, "R2 code 10");
    t_rate(1'b1, 2'b11, 32, 128, 40, "R2 code 11 R4 wide");
    t_rate(1'b0, 2'b00, 32, 32, 16, "R3 code 00 R4 half");
    t_rate(1'b0, 2'b01, 32, 64, 32, "R3 code 01");
    t_rate(1'b0, 2'b10, 32, 128, 40, "R3 code 10");
    t_rate(1'b0, 2'b11, 4, 8, FAST, "R3 R5 fast mode");
    t_reverse();
    t_quiet(1'b1, 1, "R7 creep positive");
    t_quiet(1'b1, -1, "R7 creep negative");
    t_quiet(1'b0, 1000, "R8 no valid");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule